// File: doc/BRIEF.md
# Descriptor DMA Command Sequencer

A single-channel engine that walks a chain of 16-byte command descriptors in memory. When the channel is running and active and nothing is in flight, it reads the descriptor at its command pointer as four 32-bit words. It then decodes the operation and the key and performs one of these: a data move toward or from a device stream through a start/done handshake, a small word load or store that goes through the descriptor's dependency word, a no-op, or a stop. A finished operation writes the channel status and the residual count back into the descriptor, writes all four words back to memory and advances the pointer by one descriptor.

Malformed descriptors kill the channel. A kill sets the dead flag, drops the active flag and pulses the interrupt. Condition evaluation, branching, control-register decoding and the data movement itself belong to neighbouring blocks. This block only exposes the pointer load, run, activate and wake inputs and the status flags they act on.

Top module: `desc_seq`

## Requirements
- R1: A command starts only from idle, with both `run_i` and the active flag set. It reads descriptor words 0..3 at pointer, pointer+4, pointer+8 and pointer+12. A memory access completes in any cycle where `mem_req_o` and `mem_ack_i` are both high.
- R2: Descriptor word 0 holds the request count in bits 15:0 and the command in bits 31:16. Word 1 is the physical address and word 2 is the dependency word. Word 3 holds the residual in bits 15:0 and the transfer status in bits 31:16. Within the command, the opcode is bits 15:12 and the key is bits 10:8.
- R3: Opcodes 0 to 3 are data moves. Opcodes 0 and 1 are outbound (`dev_out_o`=1), and opcodes 1 and 3 raise `dev_last_o`. `dev_len_o` carries the request count, `dev_addr_o` the address and `dev_key_o` the key. `dev_req_o` stays high, with stable fields, until `dev_done_i`.
- R4: The channel is killed by any of these: key 4 with any opcode, a data move with a zero address or a key above 3, a word operation with a key below 5, or an opcode above 7. A kill sets `dead_o`, clears `active_o` and pulses `irq_o` for one cycle. It writes nothing back and leaves the pointer unchanged.
- R5: Opcode 4 stores and opcode 5 loads. The access size comes from request-count bits 2:0: 4 bytes if bit 2 is set, otherwise 2 bytes if bit 1 is set, otherwise 1 byte. `mem_size_o` encodes this as 2, 1 or 0. A store writes the low bytes of the dependency word. A load replaces only those low bytes of the dependency word.
- R6: A word operation with key 6 makes the memory access. With key 5 or 7 it makes no access and completes normally.
- R7: On completion, descriptor bits 31:16 of word 3 take the status {run, active, dead, wake, 8'b0, `dev_stat_i`}. The residual becomes `dev_rem_i` for data moves and is kept for the other operations. All four words are written back at the pointer, the pointer advances by 16, and `cmd_done_o` pulses for one cycle.
- R8: A stop command (opcode 6 is no-op, opcode 7 is stop) clears `active_o` without a writeback and without moving the pointer.
- R9: `wake_i` sets the wake flag. The flag clears when a command starts, and the clear wins over a set in the same cycle.
- R10: `ptr_load_i` loads the pointer with the low 4 bits cleared, but only while idle and not active. Otherwise it is ignored.
- R11: Reset clears all flags, the pointer and every request. The dead flag clears in any cycle where `run_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Channel run enable |
| activate_i | input | 1 | Pulse that sets the active flag |
| wake_i | input | 1 | Pulse that sets the wake flag |
| ptr_load_i | input | 1 | Load command pointer |
| ptr_i | input | 32 | New command pointer |
| dev_stat_i | input | DSTAT_W | Device status bits folded into the status word |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data, low bytes first |
| mem_size_o | output | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_ack_i | input | 1 | Access complete this cycle |
| mem_rdata_i | input | 32 | Read data, low bytes first |
| dev_req_o | output | 1 | Device transfer in progress |
| dev_out_o | output | 1 | Direction is memory to device |
| dev_last_o | output | 1 | Final piece of the transfer |
| dev_key_o | output | 3 | Stream key |
| dev_addr_o | output | 32 | Buffer address |
| dev_len_o | output | 16 | Requested length |
| dev_done_i | input | 1 | Device transfer finished |
| dev_rem_i | input | 16 | Remaining length at finish |
| active_o | output | 1 | Active flag |
| dead_o | output | 1 | Dead flag |
| wake_o | output | 1 | Wake flag |
| irq_o | output | 1 | Kill interrupt pulse |
| cmd_done_o | output | 1 | Command written back |
| ptr_o | output | 32 | Command pointer |

## Verification
The table covers every opcode, and each kill cause is hit once. The four data moves use different lengths and device status values, so a swapped direction or last flag, or a wrong residual or status, shows up in the written-back word 3. The word operations use three sizes: one store has a request count with high bits set, to prove only bits 2:0 select the size, and the one-byte load shows the upper dependency bytes survive. Directed cases separate the start gate on `run_i` from the active flag, and show the pointer load ignored mid-command and the wake clear at command start.

// File: rtl/desc_seq_pkg.sv
package desc_seq_pkg;
  localparam int AW         = 32;
  localparam int DW         = 32;
  localparam int CNT_W      = 16;
  localparam int KEY_W      = 3;
  localparam int OP_W       = 4;
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int DESC_BYTES = DESC_WORDS * (DW / 8);

  localparam logic [OP_W-1:0] OP_OUT_MORE = 4'd0;
  localparam logic [OP_W-1:0] OP_OUT_LAST = 4'd1;
  localparam logic [OP_W-1:0] OP_IN_MORE  = 4'd2;
  localparam logic [OP_W-1:0] OP_IN_LAST  = 4'd3;
  localparam logic [OP_W-1:0] OP_STORE    = 4'd4;
  localparam logic [OP_W-1:0] OP_LOAD     = 4'd5;
  localparam logic [OP_W-1:0] OP_NOP      = 4'd6;
  localparam logic [OP_W-1:0] OP_STOP     = 4'd7;

  localparam logic [KEY_W-1:0] KEY_STREAM_TOP = 3'd3;
  localparam logic [KEY_W-1:0] KEY_ILLEGAL    = 3'd4;
  localparam logic [KEY_W-1:0] KEY_REGSPACE   = 3'd5;
  localparam logic [KEY_W-1:0] KEY_SYSTEM     = 3'd6;

  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [2:0] {ACT_KILL, ACT_STOP, ACT_DEV, ACT_MEM, ACT_DONE} act_e;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EXEC, S_DEV, S_WORD, S_WB} state_e;
endpackage

// File: rtl/desc_decode.sv
module desc_decode
  import desc_seq_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [1:0]       req_sz_i,   // request count bits 2:1
  input  logic [AW-1:0]    addr_i,
  output act_e             act_o,
  output logic             out_o,
  output logic             last_o,
  output logic             store_o,
  output logic [1:0]       size_o
);
  always_comb begin
    out_o   = (op_i == OP_OUT_MORE) || (op_i == OP_OUT_LAST);
    last_o  = (op_i == OP_OUT_LAST) || (op_i == OP_IN_LAST);
    store_o = (op_i == OP_STORE);
    size_o  = req_sz_i[1] ? 2'd2 : (req_sz_i[0] ? 2'd1 : 2'd0);
    act_o   = ACT_KILL;
    if (key_i != KEY_ILLEGAL) begin
      case (op_i)
        OP_OUT_MORE, OP_OUT_LAST, OP_IN_MORE, OP_IN_LAST:
          act_o = (addr_i == '0 || key_i > KEY_STREAM_TOP) ? ACT_KILL : ACT_DEV;
        OP_STORE, OP_LOAD:
          if (key_i < KEY_REGSPACE)     act_o = ACT_KILL;
          else if (key_i == KEY_SYSTEM) act_o = ACT_MEM;
          else                          act_o = ACT_DONE;
        OP_NOP:  act_o = ACT_DONE;
        OP_STOP: act_o = ACT_STOP;
        default: act_o = ACT_KILL;
      endcase
    end
  end
endmodule

// File: rtl/word_lane.sv
module word_lane #(
  parameter int W = 32
) (
  input  logic [1:0]   size_i,
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] new_i,
  output logic [W-1:0] merged_o
);
  localparam int NB = W / 8;
  logic [3:0]   nbytes;
  logic [W-1:0] mask;

  assign nbytes = 4'd1 << size_i;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam logic [3:0] LANE = 4'(b);
    assign mask[b*8 +: 8] = (LANE < nbytes) ? 8'hFF : 8'h00;
  end

  assign merged_o = (old_i & ~mask) | (new_i & mask);
endmodule

// File: rtl/desc_seq.sv
module desc_seq
  import desc_seq_pkg::*;
#(
  parameter int DSTAT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               activate_i,
  input  logic               wake_i,
  input  logic               ptr_load_i,
  input  logic [AW-1:0]      ptr_i,
  input  logic [DSTAT_W-1:0] dev_stat_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  output logic [1:0]         mem_size_o,
  input  logic               mem_ack_i,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               dev_req_o,
  output logic               dev_out_o,
  output logic               dev_last_o,
  output logic [KEY_W-1:0]   dev_key_o,
  output logic [AW-1:0]      dev_addr_o,
  output logic [CNT_W-1:0]   dev_len_o,
  input  logic               dev_done_i,
  input  logic [CNT_W-1:0]   dev_rem_i,
  output logic               active_o,
  output logic               dead_o,
  output logic               wake_o,
  output logic               irq_o,
  output logic               cmd_done_o,
  output logic [AW-1:0]      ptr_o
);
  localparam int PAD_W = CNT_W - 4 - DSTAT_W;

  state_e           state_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    ptr_q;
  logic [DW-1:0]    desc_q [DESC_WORDS];
  logic             active_q, dead_q, wake_q, irq_q, done_q;

  act_e             act;
  logic             is_out, is_last, is_store;
  logic [1:0]       size;
  logic [DW-1:0]    dep_merged;
  logic [CNT_W-1:0] status_now;
  logic [AW-1:0]    word_addr;

  desc_decode u_dec (
    .op_i    (desc_q[0][31:28]),
    .key_i   (desc_q[0][26:24]),
    .req_sz_i(desc_q[0][2:1]),
    .addr_i  (desc_q[1]),
    .act_o   (act),
    .out_o   (is_out),
    .last_o  (is_last),
    .store_o (is_store),
    .size_o  (size)
  );

  word_lane #(.W(DW)) u_lane (
    .size_i  (size),
    .old_i   (desc_q[2]),
    .new_i   (mem_rdata_i),
    .merged_o(dep_merged)
  );

  assign status_now = {run_i, active_q, dead_q, wake_q, {PAD_W{1'b0}}, dev_stat_i};
  assign word_addr  = ptr_q + {{(AW-IDX_W-2){1'b0}}, idx_q, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      ptr_q    <= '0;
      for (int i = 0; i < DESC_WORDS; i++) desc_q[i] <= '0;
      active_q <= 1'b0;
      dead_q   <= 1'b0;
      wake_q   <= 1'b0;
      irq_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      irq_q  <= 1'b0;
      done_q <= 1'b0;
      if (!run_i)     dead_q   <= 1'b0;
      if (wake_i)     wake_q   <= 1'b1;
      if (activate_i) active_q <= 1'b1;
      if (ptr_load_i && state_q == S_IDLE && !active_q)
        ptr_q <= {ptr_i[AW-1:4], 4'h0};
      case (state_q)
        S_IDLE: if (run_i && active_q) begin
          state_q <= S_FETCH;
          idx_q   <= '0;
          wake_q  <= 1'b0;
        end
        S_FETCH: if (mem_ack_i) begin
          desc_q[idx_q] <= mem_rdata_i;
          idx_q         <= idx_q + 1'b1;
          if (idx_q == IDX_W'(DESC_WORDS - 1)) state_q <= S_EXEC;
        end
        S_EXEC: begin
          idx_q <= '0;
          case (act)
            ACT_KILL: begin
              dead_q   <= 1'b1;
              active_q <= 1'b0;
              irq_q    <= 1'b1;
              state_q  <= S_IDLE;
            end
            ACT_STOP: begin
              active_q <= 1'b0;
              state_q  <= S_IDLE;
            end
            ACT_DEV: state_q <= S_DEV;
            ACT_MEM: state_q <= S_WORD;
            default: begin
              desc_q[3][31:16] <= status_now;
              state_q          <= S_WB;
            end
          endcase
        end
        S_DEV: if (dev_done_i) begin
          desc_q[3] <= {status_now, dev_rem_i};
          state_q   <= S_WB;
        end
        S_WORD: if (mem_ack_i) begin
          if (!is_store) desc_q[2] <= dep_merged;
          desc_q[3][31:16] <= status_now;
          state_q          <= S_WB;
        end
        S_WB: if (mem_ack_i) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
            ptr_q   <= ptr_q + AW'(DESC_BYTES);
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (state_q == S_FETCH) || (state_q == S_WORD) || (state_q == S_WB);
    mem_we_o    = (state_q == S_WB) || (state_q == S_WORD && is_store);
    mem_addr_o  = (state_q == S_WORD) ? desc_q[1] : word_addr;
    mem_wdata_o = (state_q == S_WB) ? desc_q[idx_q] : desc_q[2];
    mem_size_o  = (state_q == S_WORD) ? size : SZ_WORD;
  end

  assign dev_req_o  = (state_q == S_DEV);
  assign dev_out_o  = is_out;
  assign dev_last_o = is_last;
  assign dev_key_o  = desc_q[0][26:24];
  assign dev_addr_o = desc_q[1];
  assign dev_len_o  = desc_q[0][15:0];
  assign active_o   = active_q;
  assign dead_o     = dead_q;
  assign wake_o     = wake_q;
  assign irq_o      = irq_q;
  assign cmd_done_o = done_q;
  assign ptr_o      = ptr_q;
endmodule

// File: rtl/desc_seq_chk.sv
module desc_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic        dev_req_o,
  input logic        dev_done_i,
  input logic [15:0] dev_len_o,
  input logic [31:0] dev_addr_o,
  input logic        active_o,
  input logic        dead_o,
  input logic        wake_o,
  input logic        irq_o,
  input logic        cmd_done_o,
  input logic [31:0] ptr_o
);
  assert_irq_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_kill_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (dead_o && !active_o));

  assert_dev_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_req_o && !dev_done_i) |=> (dev_req_o && $stable(dev_len_o) && $stable(dev_addr_o)));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o |=> !cmd_done_o);

  assert_ptr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_done_o) |-> (ptr_o == $past(ptr_o) + 32'd16));

  assert_wake_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_req_o) && !mem_we_o && mem_addr_o == ptr_o) |-> !wake_o);
endmodule

bind desc_seq desc_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .dev_req_o  (dev_req_o),
  .dev_done_i (dev_done_i),
  .dev_len_o  (dev_len_o),
  .dev_addr_o (dev_addr_o),
  .active_o   (active_o),
  .dead_o     (dead_o),
  .wake_o     (wake_o),
  .irq_o      (irq_o),
  .cmd_done_o (cmd_done_o),
  .ptr_o      (ptr_o)
);

// File: tb/desc_seq_test.sv
module desc_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, activate = 1'b0, wake = 1'b0, ptr_load = 1'b0;
  logic [31:0] ptr_in = '0;
  logic [3:0]  dev_stat = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        dev_req, dev_out, dev_last, dev_done = 1'b0;
  logic [2:0]  dev_key;
  logic [31:0] dev_addr;
  logic [15:0] dev_len, dev_rem = '0;
  logic        active, dead, wake_flag, irq, cmd_done;
  logic [31:0] ptr_out;

  always #4 clk = ~clk;

  desc_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .activate_i(activate), .wake_i(wake),
    .ptr_load_i(ptr_load), .ptr_i(ptr_in), .dev_stat_i(dev_stat),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_size_o(mem_size), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .dev_req_o(dev_req), .dev_out_o(dev_out), .dev_last_o(dev_last), .dev_key_o(dev_key),
    .dev_addr_o(dev_addr), .dev_len_o(dev_len), .dev_done_i(dev_done), .dev_rem_i(dev_rem),
    .active_o(active), .dead_o(dead), .wake_o(wake_flag), .irq_o(irq),
    .cmd_done_o(cmd_done), .ptr_o(ptr_out)
  );

  // memory model: zero-wait, low bytes first
  logic [31:0] mem [64];
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[7:2]] >> (8 * mem_addr[1:0]);
  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      for (int b = 0; b < (1 << mem_size); b++)
        if (int'(mem_addr[1:0]) + b < 4)
          mem[mem_addr[7:2]][8*(int'(mem_addr[1:0])+b) +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  // device model: finishes three cycles in, residual = len/2
  int dcnt = 0;
  logic rec_out, rec_last;
  logic [15:0] rec_len;
  logic [31:0] rec_addr;
  always @(posedge clk) begin
    dev_done <= 1'b0;
    if (dev_req && !dev_done) begin
      if (dcnt == 2) begin
        dev_done <= 1'b1;
        dev_rem  <= dev_len >> 1;
        rec_out  <= dev_out;
        rec_last <= dev_last;
        rec_len  <= dev_len;
        rec_addr <= dev_addr;
        dcnt     <= 0;
      end else dcnt <= dcnt + 1;
    end
  end

  int irq_cnt = 0, done_cnt = 0, gate_viol = 0;
  always @(posedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
    if (cmd_done) done_cnt <= done_cnt + 1;
    if (mem_req && !run) gate_viol <= gate_viol + 1;
  end

  typedef struct packed {
    logic [15:0] cmd;
    logic [15:0] req;
    logic [31:0] phys;
    logic [31:0] dep;
    logic [3:0]  stat;
    logic        kill;
    logic [31:0] ptr;
    logic [31:0] w3;
    logic [31:0] dep_x;
    logic [5:0]  chk_idx;
    logic [31:0] chk_val;
    logic [2:0]  dv;      // {data move, out, last}
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0040, 32'h1000, 32'h0, 4'h5, 1'b0, 32'h50, 32'hC005_0020, 32'h0, 6'd51, 32'h0, 3'b110},
    '{16'h1000, 16'h0010, 32'h2000, 32'h0, 4'h3, 1'b0, 32'h50, 32'hC003_0008, 32'h0, 6'd51, 32'h0, 3'b111},
    '{16'h2000, 16'h0008, 32'h3000, 32'h0, 4'h0, 1'b0, 32'h50, 32'hC000_0004, 32'h0, 6'd51, 32'h0, 3'b100},
    '{16'h3300, 16'h0002, 32'h0004, 32'h0, 4'hF, 1'b0, 32'h50, 32'hC00F_0001, 32'h0, 6'd51, 32'h0, 3'b101},
    '{16'h0000, 16'h0040, 32'h0,    32'h0, 4'h0, 1'b1, 32'h40, 32'h0000_5A5A, 32'h0, 6'd51, 32'h0, 3'b000},
    '{16'h1500, 16'h0040, 32'h1000, 32'h0, 4'h0, 1'b1, 32'h40, 32'h0000_5A5A, 32'h0, 6'd51, 32'h0, 3'b000},
    '{16'h6400, 16'h0000, 32'h0,    32'h0, 4'h0, 1'b1, 32'h40, 32'h0000_5A5A, 32'h0, 6'd51, 32'h0, 3'b000},
    '{16'h9000, 16'h0000, 32'h0,    32'h0, 4'h0, 1'b1, 32'h40, 32'h0000_5A5A, 32'h0, 6'd51, 32'h0, 3'b000},
    '{16'h6000, 16'h0000, 32'h0,    32'h0, 4'h9, 1'b0, 32'h50, 32'hC009_5A5A, 32'h0, 6'd51, 32'h0, 3'b000},
    '{16'h4600, 16'h0004, 32'hC0, 32'hDEADBEEF, 4'h0, 1'b0, 32'h50, 32'hC000_5A5A, 32'hDEADBEEF, 6'd48, 32'hDEADBEEF, 3'b000},
    '{16'h4600, 16'hFFFA, 32'hC4, 32'h12345678, 4'h0, 1'b0, 32'h50, 32'hC000_5A5A, 32'h12345678, 6'd49, 32'h0000_5678, 3'b000},
    '{16'h5600, 16'h0001, 32'hC8, 32'hAABBCCDD, 4'h0, 1'b0, 32'h50, 32'hC000_5A5A, 32'hAABBCC44, 6'd50, 32'h11223344, 3'b000},
    '{16'h5600, 16'h0007, 32'hC8, 32'h0,        4'h0, 1'b0, 32'h50, 32'hC000_5A5A, 32'h11223344, 6'd50, 32'h11223344, 3'b000},
    '{16'h5200, 16'h0001, 32'hC8, 32'h0,        4'h0, 1'b1, 32'h40, 32'h0000_5A5A, 32'h0, 6'd51, 32'h0, 3'b000},
    '{16'h4700, 16'h0004, 32'hCC, 32'hFFFFFFFF, 4'h0, 1'b0, 32'h50, 32'hC000_5A5A, 32'hFFFFFFFF, 6'd51, 32'h0, 3'b000},
    '{16'h7000, 16'h0000, 32'h0,    32'h0, 4'h0, 1'b0, 32'h40, 32'h0000_5A5A, 32'h0, 6'd51, 32'h0, 3'b000}
  };

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setup(int i);
    mem[16] = {VECS[i].cmd, VECS[i].req};
    mem[17] = VECS[i].phys;
    mem[18] = VECS[i].dep;
    mem[19] = 32'h0000_5A5A;
    mem[20] = {16'h7000, 16'h0000};
    mem[21] = '0;
    mem[22] = '0;
    mem[23] = 32'h0000_5A5A;
    mem[48] = '0;
    mem[49] = '0;
    mem[50] = 32'h11223344;
    mem[51] = '0;
    dev_stat = VECS[i].stat;
  endtask

  task automatic launch(bit keep_run_low);
    run = 1'b0;
    @(negedge clk);
    run = !keep_run_low;
    ptr_load = 1'b1;
    ptr_in = 32'h40;
    @(negedge clk);
    ptr_load = 1'b0;
    activate = 1'b1;
    @(negedge clk);
    activate = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (active && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 1000) chk("R1 command never ended", 32'd1, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(int i);
    int irq0, done0;
    irq0 = irq_cnt;
    done0 = done_cnt;
    setup(i);
    launch(1'b0);
    wait_end();
    chk($sformatf("R4 dead v%0d", i), {31'b0, dead}, {31'b0, VECS[i].kill});
    chk($sformatf("R4 irq count v%0d", i), irq_cnt - irq0, {31'b0, VECS[i].kill});
    chk($sformatf("R7 R8 pointer v%0d", i), ptr_out, VECS[i].ptr);
    chk($sformatf("R2 R7 word3 v%0d", i), mem[19], VECS[i].w3);
    chk($sformatf("R5 dependency v%0d", i), mem[18], VECS[i].dep_x);
    chk($sformatf("R5 R6 target v%0d", i), mem[VECS[i].chk_idx], VECS[i].chk_val);
    chk($sformatf("R7 done pulses v%0d", i), done_cnt - done0,
        (VECS[i].kill || VECS[i].cmd[15:12] == 4'h7) ? 32'd0 : 32'd1);
    if (VECS[i].dv[2]) begin
      chk($sformatf("R3 direction v%0d", i), {31'b0, rec_out}, {31'b0, VECS[i].dv[1]});
      chk($sformatf("R3 last v%0d", i), {31'b0, rec_last}, {31'b0, VECS[i].dv[0]});
      chk($sformatf("R3 length v%0d", i), {16'b0, rec_len}, {16'b0, VECS[i].req});
      chk($sformatf("R3 address v%0d", i), rec_addr, VECS[i].phys);
    end
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset active", {31'b0, active}, 32'd0);
    chk("R11 reset dead", {31'b0, dead}, 32'd0);
    chk("R11 reset requests", {30'b0, mem_req, dev_req}, 32'd0);
    chk("R11 reset pointer", ptr_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R11 dead clears with run low (last kill was v13; force one more)
    run_vec(7);
    run = 1'b0;
    @(negedge clk);
    chk("R11 dead cleared by run low", {31'b0, dead}, 32'd0);

    // R10 pointer low bits cleared
    ptr_load = 1'b1;
    ptr_in = 32'h47;
    @(negedge clk);
    ptr_load = 1'b0;
    @(negedge clk);
    chk("R10 pointer alignment", ptr_out, 32'h40);

    // R1 start gated by run
    setup(8);
    launch(1'b1);
    repeat (10) @(negedge clk);
    chk("R1 no access while run low", gate_viol, 32'd0);
    chk("R1 active held while run low", {31'b0, active}, 32'd1);
    run = 1'b1;
    wait_end();
    chk("R1 command after run", mem[19], 32'hC009_5A5A);

    // R10 pointer load ignored while active
    setup(0);
    launch(1'b0);
    while (!dev_req) @(negedge clk);
    ptr_load = 1'b1;
    ptr_in = 32'h80;
    @(negedge clk);
    ptr_load = 1'b0;
    wait_end();
    chk("R10 load ignored while active", ptr_out, 32'h50);

    // R9 wake set, then cleared at command start
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    @(negedge clk);
    chk("R9 wake set", {31'b0, wake_flag}, 32'd1);
    run_vec(8);
    chk("R9 wake cleared by start", {31'b0, wake_flag}, 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule